// File: doc/BRIEF.md
# Four-Group Clocked-Select Bus Switch Controller

This block steers data in four independent groups. In each group, either a 4-lane input bus A or a 4-lane input bus B drives a 4-lane output Y. Each group has its own select, strobe, strobe-enable, output-enable and mode inputs. When the mode input is low the group works in registered mode. A choice register takes the select value on a rising edge of the group's own strobe, but only while the active-low strobe enable is asserted. When the mode input is high the group works in direct mode, and the select input steers the path with no strobe involved. A high output-enable input turns the path off in both modes and also freezes the choice register.

While a path is off, Y keeps the last value that was driven through it. Any change from one live path to the other passes through a one-cycle gap in which neither path is on. The block runs on one free-running system clock. Each group's strobe is brought into that domain through a two-flop synchronizer and then edge-detected. Data moves only from A/B to Y, as plain logic. A per-group flag reports whether a path is currently on.

Each group runs a four-state machine:
- `ST_OFF`: no path; Y shows the held value.
- `ST_ON_A`: A drives Y.
- `ST_ON_B`: B drives Y.
- `ST_GAP`: no path for one cycle between two live connections; Y shows the held value.

The transitions are:
- *enable*: `ST_OFF` goes to `ST_ON_A` or `ST_ON_B`, according to the target, when the enable is low.
- *disable*: any state goes to `ST_OFF` when the enable is high.
- *break*: `ST_ON_A` or `ST_ON_B` goes to `ST_GAP` when the target names the other port.
- *make*: `ST_GAP` goes to the targeted `ST_ON_x`.

Top module: `bsw_quad_top`

## Requirements
- R1: After synchronous reset, every `path_on` bit is 0, every Y lane reads 0 and every choice register holds port A.
- R2: In registered mode with the enable low, a detected rising strobe edge while `strobe_en_n` is low loads `sel` into the choice register. Value 0 selects A and value 1 selects B. The load happens on the third system clock edge after the strobe rise is presented, and Y follows two cycles later.
- R3: In registered mode, a strobe edge while `strobe_en_n` is high leaves the choice register unchanged. The current path stays on and passes live data.
- R4: In registered mode, a strobe edge while `oe_n` is high does not update the choice register, whatever `sel` and `strobe_en_n` are.
- R5: In direct mode with `oe_n` low, `sel` low selects A and `sel` high selects B. The path follows on the next system clock edge, or after the gap of R8.
- R6: A high `oe_n` turns the group off on the next system clock edge. Y then holds the last value driven through it, and the choice register is kept, so re-enabling in registered mode restores the previous port.
- R7: While a group is off, Y does not change when A or B change.
- R8: Changing from one live port to the other goes through exactly one system clock cycle in which `path_on` is 0 and Y shows the held value.
- R9: While a path is on, Y follows the selected input in the same cycle, with no register on the data path.
- R10: Groups are independent: controls and data of one group do not affect another group's Y or `path_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 4 | Per-group port select (0 = A, 1 = B) |
| strobe | input | 4 | Per-group select strobe; its rising edge loads the choice register |
| strobe_en_n | input | 4 | Per-group strobe enable, active low |
| oe_n | input | 4 | Per-group output enable, active low; high turns the path off |
| direct | input | 4 | Per-group mode: 1 = direct select, 0 = registered select |
| a_bus | input | 16 | Port A data, 4 lanes per group, group g at bits [4g+3:4g] |
| b_bus | input | 16 | Port B data, same layout as A |
| y_bus | output | 16 | Port Y data, same layout as A |
| path_on | output | 4 | Per-group flag: 1 while a path is connected |

## Verification
The bench goes after the gap cycle on a port change. A design that switched straight across would show B data with `path_on` high one cycle early. It checks that Y stays frozen while the group is off and A and B move underneath it; a design that kept sampling the inputs would leak the new data out. It strobes while the strobe enable is high and while the output is disabled; a design that ignored either gate would come back on the wrong port after re-enable. It also checks that activity in one group leaves the other groups' outputs alone, and that Y tracks live data within the same cycle while a path is on.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ON_A = 2'd1,
        ST_ON_B = 2'd2,
        ST_GAP  = 2'd3
    } bsw_state_e;

    localparam logic PORT_A = 1'b0;
    localparam logic PORT_B = 1'b1;
endpackage

// File: rtl/bsw_edge_detect.sv
module bsw_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    genvar i;
    generate
        for (i = 0; i < CHAIN; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R2: a detected rise lasts a single cycle
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/bsw_sel_reg.sv
module bsw_sel_reg (
    input  logic clk,
    input  logic rst,
    input  logic strobe_rise,
    input  logic strobe_en_n,
    input  logic oe_n,
    input  logic direct,
    input  logic sel,
    output logic choice_q
);
    import bsw_pkg::*;

    logic load;

    always_comb begin
        load = strobe_rise & ~strobe_en_n & ~oe_n & ~direct;
    end

    always_ff @(posedge clk) begin
        if (rst)       choice_q <= PORT_A;
        else if (load) choice_q <= sel;
    end

    // R3: strobe with enable deasserted keeps the register
    p_en_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        strobe_en_n |=> $stable(choice_q));

    // R4: output disabled freezes the register
    p_oe_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> $stable(choice_q));
endmodule

// File: rtl/bsw_group.sv
module bsw_group #(
    parameter int LANES      = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             strobe,
    input  logic             strobe_en_n,
    input  logic             oe_n,
    input  logic             direct,
    input  logic [LANES-1:0] a_in,
    input  logic [LANES-1:0] b_in,
    output logic [LANES-1:0] y_out,
    output logic             on
);
    import bsw_pkg::*;

    logic       strobe_rise;
    logic       choice_q;
    logic       target;
    bsw_state_e state_q, state_d;
    logic [LANES-1:0] hold_q;

    bsw_edge_detect #(.STAGES(SYNC_DEPTH)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .async_in (strobe),
        .rise     (strobe_rise)
    );

    bsw_sel_reg u_choice (
        .clk         (clk),
        .rst         (rst),
        .strobe_rise (strobe_rise),
        .strobe_en_n (strobe_en_n),
        .oe_n        (oe_n),
        .direct      (direct),
        .sel         (sel),
        .choice_q    (choice_q)
    );

    always_comb begin
        target = direct ? sel : choice_q;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (!oe_n) state_d = (target == PORT_B) ? ST_ON_B : ST_ON_A;
            end
            ST_ON_A: begin
                if (oe_n)                  state_d = ST_OFF;
                else if (target == PORT_B) state_d = ST_GAP;
            end
            ST_ON_B: begin
                if (oe_n)                  state_d = ST_OFF;
                else if (target == PORT_A) state_d = ST_GAP;
            end
            ST_GAP: begin
                if (oe_n) state_d = ST_OFF;
                else      state_d = (target == PORT_B) ? ST_ON_B : ST_ON_A;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // last-value hold
    always_ff @(posedge clk) begin
        if (rst)                    hold_q <= '0;
        else if (state_q == ST_ON_A) hold_q <= a_in;
        else if (state_q == ST_ON_B) hold_q <= b_in;
    end

    // outputs
    always_comb begin
        y_out = hold_q;
        on    = 1'b0;
        unique case (state_q)
            ST_ON_A: begin y_out = a_in; on = 1'b1; end
            ST_ON_B: begin y_out = b_in; on = 1'b1; end
            ST_OFF, ST_GAP: begin y_out = hold_q; on = 1'b0; end
            default: begin y_out = hold_q; on = 1'b0; end
        endcase
    end

    // R8: never cross directly between live ports
    p_bbm_ab_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ON_A) |=> (state_q != ST_ON_B));
    p_bbm_ba_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ON_B) |=> (state_q != ST_ON_A));

    // R6: disable turns the path off on the next edge
    p_oe_off_r6: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> !on);

    // R7: held value does not move while off
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !on |=> $stable(hold_q));
endmodule

// File: rtl/bsw_quad_top.sv
module bsw_quad_top #(
    parameter int GROUPS     = 4,
    parameter int LANES      = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [GROUPS-1:0]         sel,
    input  logic [GROUPS-1:0]         strobe,
    input  logic [GROUPS-1:0]         strobe_en_n,
    input  logic [GROUPS-1:0]         oe_n,
    input  logic [GROUPS-1:0]         direct,
    input  logic [GROUPS*LANES-1:0]   a_bus,
    input  logic [GROUPS*LANES-1:0]   b_bus,
    output logic [GROUPS*LANES-1:0]   y_bus,
    output logic [GROUPS-1:0]         path_on
);
    genvar g;
    generate
        for (g = 0; g < GROUPS; g++) begin : g_grp
            bsw_group #(
                .LANES      (LANES),
                .SYNC_DEPTH (SYNC_DEPTH)
            ) u_grp (
                .clk         (clk),
                .rst         (rst),
                .sel         (sel[g]),
                .strobe      (strobe[g]),
                .strobe_en_n (strobe_en_n[g]),
                .oe_n        (oe_n[g]),
                .direct      (direct[g]),
                .a_in        (a_bus[g*LANES +: LANES]),
                .b_in        (b_bus[g*LANES +: LANES]),
                .y_out       (y_bus[g*LANES +: LANES]),
                .on          (path_on[g])
            );
        end
    endgenerate

    // R1: nothing is connected in the cycle after reset
    p_reset_off_r1: assert property (@(posedge clk)
        rst |=> (path_on == '0));
endmodule

// File: tb/bsw_quad_top_test.sv
`timescale 1ns/1ps
module bsw_quad_top_test;
    localparam int G = 4;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [G-1:0]   sel = '0, strobe = '0, strobe_en_n = '1, oe_n = '1, direct = '0;
    logic [G*W-1:0] a_bus = '0, b_bus = '0;
    logic [G*W-1:0] y_bus;
    logic [G-1:0]   path_on;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bsw_quad_top uut (
        .clk(clk), .rst(rst), .sel(sel), .strobe(strobe),
        .strobe_en_n(strobe_en_n), .oe_n(oe_n), .direct(direct),
        .a_bus(a_bus), .b_bus(b_bus), .y_bus(y_bus), .path_on(path_on)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ylane(input int g);
        return y_bus[g*W +: W];
    endfunction

    task automatic pulse(input int g);
        strobe[g] = 1'b1;
        tick(4);
        strobe[g] = 1'b0;
        tick(4);
    endtask

    task automatic t_reset;
        check("R1 path_on", {28'd0, path_on}, 32'd0);
        check("R1 y_bus", {16'd0, y_bus}, 32'd0);
    endtask

    task automatic t_direct;
        direct[0] = 1'b1; oe_n[0] = 1'b0; sel[0] = 1'b0;
        a_bus[3:0] = 4'h5; b_bus[3:0] = 4'hA;
        tick(1);
        check("R5 on A flag", {31'd0, path_on[0]}, 32'd1);
        check("R5 y from A", {28'd0, ylane(0)}, 32'h5);
        a_bus[3:0] = 4'h6; #1;
        check("R9 live A", {28'd0, ylane(0)}, 32'h6);
        sel[0] = 1'b1;
        tick(1);
        check("R8 gap flag", {31'd0, path_on[0]}, 32'd0);
        check("R8 gap holds", {28'd0, ylane(0)}, 32'h6);
        tick(1);
        check("R5 on B flag", {31'd0, path_on[0]}, 32'd1);
        check("R5 y from B", {28'd0, ylane(0)}, 32'hA);
    endtask

    task automatic t_hold;
        oe_n[0] = 1'b1;
        tick(1);
        check("R6 off", {31'd0, path_on[0]}, 32'd0);
        check("R6 held", {28'd0, ylane(0)}, 32'hA);
        a_bus[3:0] = 4'h9; b_bus[3:0] = 4'h3; #1;
        check("R7 frozen now", {28'd0, ylane(0)}, 32'hA);
        tick(3);
        check("R7 frozen later", {28'd0, ylane(0)}, 32'hA);
    endtask

    task automatic t_registered;
        a_bus[7:4] = 4'h1; b_bus[7:4] = 4'h2;
        direct[1] = 1'b0; strobe_en_n[1] = 1'b0; oe_n[1] = 1'b0; sel[1] = 1'b1;
        tick(1);
        check("R1 reg starts A", {28'd0, ylane(1)}, 32'h1);
        pulse(1);
        check("R2 load 1 -> B", {28'd0, ylane(1)}, 32'h2);
        check("R2 on", {31'd0, path_on[1]}, 32'd1);
        b_bus[7:4] = 4'h7; #1;
        check("R9 live B", {28'd0, ylane(1)}, 32'h7);
        sel[1] = 1'b0; strobe_en_n[1] = 1'b1;
        pulse(1);
        check("R3 strobe ignored", {28'd0, ylane(1)}, 32'h7);
        check("R3 still on", {31'd0, path_on[1]}, 32'd1);
        oe_n[1] = 1'b1; strobe_en_n[1] = 1'b0;
        pulse(1);
        check("R6 off held", {28'd0, ylane(1)}, 32'h7);
        oe_n[1] = 1'b0;
        tick(2);
        check("R4 reg kept B", {28'd0, ylane(1)}, 32'h7);
        b_bus[7:4] = 4'h4; #1;
        check("R6 restored B live", {28'd0, ylane(1)}, 32'h4);
        pulse(1);
        check("R2 load 0 -> A", {28'd0, ylane(1)}, 32'h1);
        check("R10 group0 untouched", {28'd0, ylane(0)}, 32'hA);
        check("R10 group0 off", {31'd0, path_on[0]}, 32'd0);
        check("R10 groups 2,3 idle", {24'd0, y_bus[15:8]}, 32'd0);
        check("R10 groups 2,3 off", {30'd0, path_on[3:2]}, 32'd0);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_direct();
        t_hold();
        t_registered();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule